// File: doc/BRIEF.md
# Dual-Channel Serial Control Register File

This block is the processor-facing register logic of a two-channel asynchronous serial controller. Each channel owns sixteen write registers and a set of read registers. A byte-wide bus with one address bit for control/data and one for channel selection reaches all of them. The control port has no per-register address. A first control write to a channel loads a 4-bit register pointer, the next control access uses it, and the pointer then falls back to zero by itself. The zero-pointer write also carries a command field. Among its commands are a point-high code that adds 8 to the pointer, a code that drops the pending transmit interrupt and a code that releases the receive level from in-service.

Write register 9 carries reset commands. One code soft-resets channel B, another soft-resets channel A, and a third hard-resets both. Each reset leaves a defined set of bits held, forced or cleared. The block turns the character-format registers and the 16-bit time constant into registered per-channel decode outputs: a total clock divisor, data bits, parity and stop mode. A data-port write is handed to the serializer as a one-cycle strobe. When local loopback is selected, the byte goes straight into the receive buffer instead.

Top module: `serreg_file`

## Requirements
- R1: With the pointer at 0, a control write loads the pointer from bits 2:0. If bits 5:3 are 001, the pointer also gets 8 added.
- R2: A control write with a nonzero pointer stores the byte in that write register and returns the pointer to 0. The next control read then returns RR0.
- R3: A control read returns the read register the pointer selects, with the data on bus_rdata_o one cycle later, and returns the pointer to 0.
- R4: A zero-pointer command with bits 5:3 = 101 clears the channel's transmit-pending flag.
- R5: A zero-pointer command with bits 5:3 = 111 clears the receive in-service flag. A transmit-pending flag held back by it then shows in RR3.
- R6: A write of WR9 with bits 7:6 = 01 soft-resets channel B, and 10 soft-resets channel A. In the reset channel, RR0 keeps bits 7,5,4,3 and gets bits 6 and 2 set, RR1 keeps bit 0 and gets bits 2:1 set, and WR15 (read back as RR15) becomes 0xF8. WR5 keeps only bits 6,5,0 and WR4 gets bit 2 set. The other channel is unchanged.
- R7: A write of WR9 with bits 7:6 = 11 resets both channels as in R6. It also clears WR10, loads WR11 with 0x08, sets WR9 bits 7:6 and sets the loopback bit (bit 4) of WR14.
- R8: Writes to WR12 and WR13 read back unchanged from RR12 and RR13.
- R9: The divisor output equals (WR13:WR12 + 2) times 1, 16, 32 or 64 for WR4[7:6] = 00, 01, 10, 11. Data bits come from WR5[6:5] (00=5, 01=7, 10=6, 11=8). Parity enable is WR4[0], even parity is WR4[1], and two stop bits is WR4[3:2]=11.
- R10: A data write with WR5 bit 3 and WR14 bit 4 set loads RR8, sets RR0 bit 0, sets the receive-pending and receive in-service flags, and gives no transmit strobe.
- R11: After the device reset input, RR0 reads 0x04 (transmit buffer empty) and every other register reads 0. RR0 bit 2 never clears afterwards.
- R12: A write of WR3 with bit 4 set also sets RR0 bit 4.
- R13: A data read returns RR8 and clears RR0 bit 0 and both receive flags.
- R14: A data write sets RR0 bit 2, RR1 bit 0 and the transmit-pending flag. With WR5 bit 3 set and loopback off, it pulses tx_valid_o for that channel for one cycle with the byte on tx_data_o. RR3, read on channel A, shows bit 5 = A receive, 4 = A transmit, 2 = B receive, 1 = B transmit. A transmit bit shows only when WR1 bit 1 is set and receive is not in service. RR3 reads 0 on channel B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high device reset |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_data_sel_i | input | 1 | 0 = control port, 1 = data port |
| bus_chan_i | input | 1 | 0 = channel A, 1 = channel B |
| bus_wdata_i | input | 8 | Write byte |
| bus_rdata_o | output | 8 | Read byte, registered |
| tx_valid_o | output | 2 | Per-channel transmit strobe (bit 0 = A) |
| tx_data_o | output | 16 | Per-channel transmit byte (7:0 = A) |
| fmt_div_o | output | 46 | Per-channel total clock divisor, 23 bits each |
| fmt_bits_o | output | 8 | Per-channel data bit count, 4 bits each |
| fmt_par_en_o | output | 2 | Per-channel parity enable |
| fmt_par_even_o | output | 2 | Per-channel even parity |
| fmt_stop2_o | output | 2 | Per-channel two stop bits |

## Verification
The hardest state to reach is a transmit interrupt held back behind a receive in service, because nothing from the outside raises both flags together. The bench enables loopback and the transmit interrupt, then issues one data write. That write raises transmit-pending and receive-in-service in the same cycle. The bench then reads RR3 to see that the transmit bit is masked, releases the in-service level with the 111 command to uncover it, and finally drains the receive byte. Cross-channel resets are checked the same way: a WR9 written on one channel resets the other, so the bench reads back both channels afterwards.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int BYTE_W = 8;
  localparam int REG_N  = 16;
  localparam int PTR_W  = $clog2(REG_N);
  localparam int TC_W   = 2 * BYTE_W;
  localparam int DIV_W  = TC_W + 7;
  localparam int NCH    = 2;

  // zero-pointer command codes (bits 5:3)
  localparam logic [2:0] CMD_POINT_HI = 3'b001;
  localparam logic [2:0] CMD_TX_ACK   = 3'b101;
  localparam logic [2:0] CMD_IUS_ACK  = 3'b111;

  // register indexes whose contents the logic decodes
  localparam logic [PTR_W-1:0] IX_SELF  = 4'd0;
  localparam logic [PTR_W-1:0] IX_IEN   = 4'd1;
  localparam logic [PTR_W-1:0] IX_RXC   = 4'd3;
  localparam logic [PTR_W-1:0] IX_FMT   = 4'd4;
  localparam logic [PTR_W-1:0] IX_TXC   = 4'd5;
  localparam logic [PTR_W-1:0] IX_RSTC  = 4'd9;
  localparam logic [PTR_W-1:0] IX_ENC   = 4'd10;
  localparam logic [PTR_W-1:0] IX_CLKS  = 4'd11;
  localparam logic [PTR_W-1:0] IX_TCLO  = 4'd12;
  localparam logic [PTR_W-1:0] IX_TCHI  = 4'd13;
  localparam logic [PTR_W-1:0] IX_AUX   = 4'd14;
  localparam logic [PTR_W-1:0] IX_EXT   = 4'd15;
  localparam logic [PTR_W-1:0] IX_RXBUF = 4'd8;
  localparam logic [PTR_W-1:0] IX_STAT  = 4'd0;
  localparam logic [PTR_W-1:0] IX_SPEC  = 4'd1;
  localparam logic [PTR_W-1:0] IX_PEND  = 4'd3;

  // reset masks and forced values
  localparam logic [7:0] K_IEN_KEEP   = 8'h24;
  localparam logic [7:0] K_RXC_KEEP   = 8'hFE;
  localparam logic [7:0] K_FMT_SET    = 8'h04;
  localparam logic [7:0] K_TXC_KEEP   = 8'h61;
  localparam logic [7:0] K_RSTC_SOFT  = 8'hDF;
  localparam logic [7:0] K_RSTC_HKEEP = 8'h03;
  localparam logic [7:0] K_RSTC_HSET  = 8'hC0;
  localparam logic [7:0] K_ENC_KEEP   = 8'h60;
  localparam logic [7:0] K_CLKS_HARD  = 8'h08;
  localparam logic [7:0] K_AUX_SKEEP  = 8'hC3;
  localparam logic [7:0] K_AUX_SSET   = 8'h20;
  localparam logic [7:0] K_AUX_HKEEP  = 8'hC0;
  localparam logic [7:0] K_AUX_HSET   = 8'h30;
  localparam logic [7:0] K_EXT_RST    = 8'hF8;
  localparam logic [7:0] K_STAT_KEEP  = 8'hB8;
  localparam logic [7:0] K_STAT_SET   = 8'h44;
  localparam logic [7:0] K_SPEC_KEEP  = 8'h01;
  localparam logic [7:0] K_SPEC_SET   = 8'h06;
  localparam logic [7:0] K_STAT_PWR   = 8'h04;

  // bit positions
  localparam int B_RXAV   = 0;
  localparam int B_TXMT   = 2;
  localparam int B_HUNT   = 4;
  localparam int B_ALLSNT = 0;
  localparam int B_TXEN   = 3;
  localparam int B_LOOP   = 4;
  localparam int B_TXIE   = 1;
endpackage

// File: rtl/serreg_fmt.sv
module serreg_fmt
  import serreg_pkg::*;
#(
  parameter int TCW  = TC_W,
  parameter int DVW  = TCW + 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [7:0]     fmt_reg,
  input  logic [7:0]     txc_reg,
  input  logic [TCW-1:0] tconst,
  output logic [DVW-1:0] div_o,
  output logic [3:0]     bits_o,
  output logic           par_en_o,
  output logic           par_even_o,
  output logic           stop2_o
);
  logic [DVW-1:0] base_w;
  logic [DVW-1:0] div_w;
  logic [3:0]     bits_w;

  assign base_w = {{(DVW-TCW){1'b0}}, tconst} + DVW'(2);

  always_comb begin
    unique case (fmt_reg[7:6])
      2'b00:   div_w = base_w;
      2'b01:   div_w = base_w << 4;
      2'b10:   div_w = base_w << 5;
      default: div_w = base_w << 6;
    endcase
    unique case (txc_reg[6:5])
      2'b00:   bits_w = 4'd5;
      2'b01:   bits_w = 4'd7;
      2'b10:   bits_w = 4'd6;
      default: bits_w = 4'd8;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_o      <= '0;
      bits_o     <= '0;
      par_en_o   <= 1'b0;
      par_even_o <= 1'b0;
      stop2_o    <= 1'b0;
    end else begin
      div_o      <= div_w;
      bits_o     <= bits_w;
      par_en_o   <= fmt_reg[0];
      par_even_o <= fmt_reg[1];
      stop2_o    <= (fmt_reg[3:2] == 2'b11);
    end
  end

  assert_bits_range_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (bits_o >= 4'd5 && bits_o <= 4'd8));
endmodule

// File: rtl/serreg_chan.sv
module serreg_chan
  import serreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             soft_rst,
  input  logic             hard_rst,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic             dat_wr,
  input  logic             dat_rd,
  input  logic [7:0]       wdata,
  output logic [PTR_W-1:0] ptr_o,
  output logic [7:0]       ctl_rdata_o,
  output logic [7:0]       rx_byte_o,
  output logic             rx_pend_o,
  output logic             tx_vis_o,
  output logic             tx_valid_o,
  output logic [7:0]       tx_data_o,
  output logic [DIV_W-1:0] div_o,
  output logic [3:0]       bits_o,
  output logic             par_en_o,
  output logic             par_even_o,
  output logic             stop2_o
);
  logic [7:0]       wreg_q [REG_N];
  logic [7:0]       stat_q, spec_q, rxbuf_q, tclo_q, tchi_q;
  logic [PTR_W-1:0] ptr_q;
  logic             tx_ip_q, rx_ip_q, rx_ius_q;
  logic             any_rst;
  logic [2:0]       cmd;
  logic             loop_on, tx_on, rst_code;

  assign any_rst  = soft_rst | hard_rst;
  assign cmd      = wdata[5:3];
  assign tx_on    = wreg_q[IX_TXC][B_TXEN];
  assign loop_on  = wreg_q[IX_AUX][B_LOOP];
  assign rst_code = (ptr_q == IX_RSTC) && (wdata[7:6] != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_N; i++) wreg_q[i] <= '0;
      stat_q     <= K_STAT_PWR;
      spec_q     <= '0;
      rxbuf_q    <= '0;
      tclo_q     <= '0;
      tchi_q     <= '0;
      ptr_q      <= '0;
      tx_ip_q    <= 1'b0;
      rx_ip_q    <= 1'b0;
      rx_ius_q   <= 1'b0;
      tx_valid_o <= 1'b0;
      tx_data_o  <= '0;
    end else begin
      tx_valid_o <= 1'b0;
      if (any_rst) begin
        ptr_q            <= '0;
        tx_ip_q          <= 1'b0;
        rx_ip_q          <= 1'b0;
        rx_ius_q         <= 1'b0;
        wreg_q[IX_SELF]  <= '0;
        wreg_q[IX_IEN]   <= wreg_q[IX_IEN] & K_IEN_KEEP;
        wreg_q[IX_RXC]   <= wreg_q[IX_RXC] & K_RXC_KEEP;
        wreg_q[IX_FMT]   <= wreg_q[IX_FMT] | K_FMT_SET;
        wreg_q[IX_TXC]   <= wreg_q[IX_TXC] & K_TXC_KEEP;
        wreg_q[IX_EXT]   <= K_EXT_RST;
        stat_q           <= (stat_q & K_STAT_KEEP) | K_STAT_SET;
        spec_q           <= (spec_q & K_SPEC_KEEP) | K_SPEC_SET;
        if (hard_rst) begin
          wreg_q[IX_RSTC] <= (wreg_q[IX_RSTC] & K_RSTC_HKEEP) | K_RSTC_HSET;
          wreg_q[IX_ENC]  <= '0;
          wreg_q[IX_CLKS] <= K_CLKS_HARD;
          wreg_q[IX_AUX]  <= (wreg_q[IX_AUX] & K_AUX_HKEEP) | K_AUX_HSET;
        end else begin
          wreg_q[IX_RSTC] <= wreg_q[IX_RSTC] & K_RSTC_SOFT;
          wreg_q[IX_ENC]  <= wreg_q[IX_ENC] & K_ENC_KEEP;
          wreg_q[IX_AUX]  <= (wreg_q[IX_AUX] & K_AUX_SKEEP) | K_AUX_SSET;
        end
      end else begin
        if (ctl_wr) begin
          if (ptr_q == '0) begin
            ptr_q <= {cmd == CMD_POINT_HI, wdata[2:0]};
            if (cmd == CMD_TX_ACK)  tx_ip_q  <= 1'b0;
            if (cmd == CMD_IUS_ACK) rx_ius_q <= 1'b0;
          end else begin
            ptr_q <= '0;
            if (!rst_code) wreg_q[ptr_q] <= wdata;
            if (ptr_q == IX_RXC && wdata[B_HUNT]) stat_q[B_HUNT] <= 1'b1;
            if (ptr_q == IX_FMT)  spec_q[B_ALLSNT] <= 1'b1;
            if (ptr_q == IX_TCLO) tclo_q <= wdata;
            if (ptr_q == IX_TCHI) tchi_q <= wdata;
          end
        end
        if (ctl_rd) ptr_q <= '0;
        if (dat_wr) begin
          tx_data_o        <= wdata;
          stat_q[B_TXMT]   <= 1'b1;
          spec_q[B_ALLSNT] <= 1'b1;
          tx_ip_q          <= 1'b1;
          if (tx_on) begin
            if (loop_on) begin
              rxbuf_q        <= wdata;
              stat_q[B_RXAV] <= 1'b1;
              rx_ip_q        <= 1'b1;
              rx_ius_q       <= 1'b1;
            end else begin
              tx_valid_o <= 1'b1;
            end
          end
        end
        if (dat_rd) begin
          stat_q[B_RXAV] <= 1'b0;
          rx_ip_q        <= 1'b0;
          rx_ius_q       <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (ptr_q)
      IX_STAT:  ctl_rdata_o = stat_q;
      IX_SPEC:  ctl_rdata_o = spec_q;
      IX_RXBUF: ctl_rdata_o = rxbuf_q;
      IX_TCLO:  ctl_rdata_o = tclo_q;
      IX_TCHI:  ctl_rdata_o = tchi_q;
      IX_EXT:   ctl_rdata_o = wreg_q[IX_EXT];
      default:  ctl_rdata_o = '0;
    endcase
  end

  assign ptr_o     = ptr_q;
  assign rx_byte_o = rxbuf_q;
  assign rx_pend_o = rx_ip_q;
  assign tx_vis_o  = tx_ip_q & wreg_q[IX_IEN][B_TXIE] & ~rx_ius_q;

  serreg_fmt #(.TCW(TC_W), .DVW(DIV_W)) fmt_i (
    .clk       (clk),
    .rst       (rst),
    .fmt_reg   (wreg_q[IX_FMT]),
    .txc_reg   (wreg_q[IX_TXC]),
    .tconst    ({wreg_q[IX_TCHI], wreg_q[IX_TCLO]}),
    .div_o     (div_o),
    .bits_o    (bits_o),
    .par_en_o  (par_en_o),
    .par_even_o(par_even_o),
    .stop2_o   (stop2_o)
  );

  assert_ptr_load_R1: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ptr_q == '0 && !any_rst) |=>
      ptr_q == {$past(wdata[5:3]) == CMD_POINT_HI, $past(wdata[2:0])});

  assert_ptr_home_R2: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ptr_q != '0) |=> ptr_q == '0);

  assert_rd_home_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_rd |=> ptr_q == '0);

  assert_soft_vals_R6: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !hard_rst) |=>
      (stat_q[6] && stat_q[B_TXMT] && spec_q[2:1] == 2'b11 && wreg_q[IX_EXT] == K_EXT_RST));

  assert_hard_vals_R7: assert property (@(posedge clk) disable iff (rst)
    hard_rst |=> (wreg_q[IX_ENC] == '0 && wreg_q[IX_CLKS] == K_CLKS_HARD &&
                  wreg_q[IX_RSTC][7:6] == 2'b11 && wreg_q[IX_AUX][B_LOOP]));

  assert_mirror_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && ptr_q == IX_TCLO && !any_rst) |=> tclo_q == $past(wdata));

  assert_loopback_R10: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && tx_on && loop_on && !any_rst) |=>
      (stat_q[B_RXAV] && rxbuf_q == $past(wdata) && !tx_valid_o));

  assert_txempty_R11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> stat_q[B_TXMT]);
endmodule

// File: rtl/serreg_file.sv
module serreg_file
  import serreg_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr_i,
  input  logic                   bus_rd_i,
  input  logic                   bus_data_sel_i,
  input  logic                   bus_chan_i,
  input  logic [7:0]             bus_wdata_i,
  output logic [7:0]             bus_rdata_o,
  output logic [NCH-1:0]         tx_valid_o,
  output logic [NCH*8-1:0]       tx_data_o,
  output logic [NCH*DIV_W-1:0]   fmt_div_o,
  output logic [NCH*4-1:0]       fmt_bits_o,
  output logic [NCH-1:0]         fmt_par_en_o,
  output logic [NCH-1:0]         fmt_par_even_o,
  output logic [NCH-1:0]         fmt_stop2_o
);
  logic [PTR_W-1:0] ptr_w   [NCH];
  logic [7:0]       crd_w   [NCH];
  logic [7:0]       rxb_w   [NCH];
  logic [NCH-1:0]   rxp_w, txv_w;
  logic [NCH-1:0]   soft_w;
  logic             rst_cmd, soft_a, soft_b, hard_all;
  logic [7:0]       pend_w;
  logic [7:0]       rd_next;

  // WR9 reset command decode, shared by both channels
  assign rst_cmd  = bus_wr_i && !bus_data_sel_i && (ptr_w[bus_chan_i] == IX_RSTC);
  assign soft_b   = rst_cmd && (bus_wdata_i[7:6] == 2'b01);
  assign soft_a   = rst_cmd && (bus_wdata_i[7:6] == 2'b10);
  assign hard_all = rst_cmd && (bus_wdata_i[7:6] == 2'b11);
  assign soft_w   = {soft_b, soft_a};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic sel;
    assign sel = (bus_chan_i == c[0]);
    serreg_chan chan_i (
      .clk        (clk),
      .rst        (rst),
      .soft_rst   (soft_w[c]),
      .hard_rst   (hard_all),
      .ctl_wr     (bus_wr_i && !bus_data_sel_i && sel),
      .ctl_rd     (bus_rd_i && !bus_data_sel_i && sel),
      .dat_wr     (bus_wr_i &&  bus_data_sel_i && sel),
      .dat_rd     (bus_rd_i &&  bus_data_sel_i && sel),
      .wdata      (bus_wdata_i),
      .ptr_o      (ptr_w[c]),
      .ctl_rdata_o(crd_w[c]),
      .rx_byte_o  (rxb_w[c]),
      .rx_pend_o  (rxp_w[c]),
      .tx_vis_o   (txv_w[c]),
      .tx_valid_o (tx_valid_o[c]),
      .tx_data_o  (tx_data_o[c*8 +: 8]),
      .div_o      (fmt_div_o[c*DIV_W +: DIV_W]),
      .bits_o     (fmt_bits_o[c*4 +: 4]),
      .par_en_o   (fmt_par_en_o[c]),
      .par_even_o (fmt_par_even_o[c]),
      .stop2_o    (fmt_stop2_o[c])
    );
  end

  // pending summary, visible through channel A only
  assign pend_w = {2'b00, rxp_w[0], txv_w[0], 1'b0, rxp_w[1], txv_w[1], 1'b0};

  always_comb begin
    if (bus_data_sel_i)                        rd_next = rxb_w[bus_chan_i];
    else if (ptr_w[bus_chan_i] == IX_PEND)     rd_next = bus_chan_i ? 8'h00 : pend_w;
    else                                       rd_next = crd_w[bus_chan_i];
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= rd_next;
  end

  assert_one_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({soft_a, soft_b, hard_all}));

  assert_rr3_b_zero_R14: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && !bus_data_sel_i && bus_chan_i && ptr_w[1] == IX_PEND) |=> bus_rdata_o == 8'h00);
endmodule

// File: tb/serreg_file_tb.sv
`timescale 1ns/1ps
module serreg_file_tb_top;
  import serreg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_dsel = 1'b0, bus_ch = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [NCH-1:0] tx_valid;
  logic [NCH*8-1:0] tx_data;
  logic [NCH*DIV_W-1:0] fmt_div;
  logic [NCH*4-1:0] fmt_bits;
  logic [NCH-1:0] par_en, par_even, stop2;
  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  serreg_file dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_data_sel_i(bus_dsel), .bus_chan_i(bus_ch), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .fmt_div_o(fmt_div), .fmt_bits_o(fmt_bits), .fmt_par_en_o(par_en),
    .fmt_par_even_o(par_even), .fmt_stop2_o(stop2)
  );

  // {channel, write reg, write value, read reg, expected}
  localparam logic [39:0] VEC [8] = '{
    {8'd0, 8'd12, 8'h5A, 8'd12, 8'h5A},
    {8'd0, 8'd13, 8'hC3, 8'd13, 8'hC3},
    {8'd1, 8'd12, 8'h11, 8'd12, 8'h11},
    {8'd1, 8'd13, 8'h22, 8'd13, 8'h22},
    {8'd0, 8'd3,  8'h10, 8'd0,  8'h14},
    {8'd1, 8'd4,  8'h00, 8'd1,  8'h01},
    {8'd1, 8'd3,  8'h01, 8'd0,  8'h04},
    {8'd0, 8'd2,  8'h77, 8'd13, 8'hC3}
  };

  task automatic check(input string tag, input longint got, input longint exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic dsel, input logic ch, input logic [7:0] d);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_dsel = dsel; bus_ch = ch; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] ptr_byte(input int r);
    return {2'b00, (r >= 8) ? 3'b001 : 3'b000, 3'(r)};
  endfunction

  task automatic ctl_write(input logic ch, input int r, input logic [7:0] v);
    if (r != 0) bus_op(1'b1, 1'b0, ch, ptr_byte(r));
    bus_op(1'b1, 1'b0, ch, v);
  endtask

  task automatic ctl_read(input logic ch, input int r, output logic [7:0] v);
    if (r != 0) bus_op(1'b1, 1'b0, ch, ptr_byte(r));
    bus_op(1'b0, 1'b0, ch, 8'h00);
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    check("R11 rdata after reset", bus_rdata, 8'h00);
    ctl_read(1'b0, 0, rv);  check("R11 RR0 A", rv, 8'h04);
    ctl_read(1'b1, 1, rv);  check("R11 RR1 B", rv, 8'h00);

    for (int i = 0; i < 8; i++) begin
      ctl_write(VEC[i][32], int'(VEC[i][31:24]), VEC[i][23:16]);
      ctl_read(VEC[i][32], int'(VEC[i][15:8]), rv);
      check($sformatf("R8 R12 R14 table %0d", i), rv, VEC[i][7:0]);
    end

    // R1: point-high command
    bus_op(1'b1, 1'b0, 1'b0, 8'h0D);
    bus_op(1'b1, 1'b0, 1'b0, 8'hAB);
    ctl_read(1'b0, 13, rv); check("R1 point high WR13", rv, 8'hAB);

    // R2 / R3: pointer self-return
    ctl_write(1'b0, 12, 8'h44);
    ctl_read(1'b0, 0, rv);  check("R2 pointer back to 0", rv, 8'h14);
    ctl_read(1'b0, 12, rv); check("R3 read RR12", rv, 8'h44);
    ctl_read(1'b0, 0, rv);  check("R3 pointer back after read", rv, 8'h14);

    // R9: format decode
    ctl_write(1'b0, 4, 8'h4F); ctl_write(1'b0, 5, 8'h68);
    ctl_write(1'b0, 12, 8'h0A); ctl_write(1'b0, 13, 8'h00);
    idle(2);
    check("R9 div x16", fmt_div[DIV_W-1:0], 192);
    check("R9 bits 8", fmt_bits[3:0], 8);
    check("R9 parity/stop", {par_en[0], par_even[0], stop2[0]}, 3'b111);
    ctl_write(1'b0, 4, 8'hC0); ctl_write(1'b0, 5, 8'h20);
    idle(2);
    check("R9 div x64", fmt_div[DIV_W-1:0], 768);
    check("R9 bits 7 no parity", {fmt_bits[3:0], par_en[0], stop2[0]}, {4'd7, 2'b00});
    ctl_write(1'b0, 4, 8'h00); ctl_write(1'b0, 12, 8'hFE); ctl_write(1'b0, 13, 8'hFF);
    idle(2);
    check("R9 div max x1", fmt_div[DIV_W-1:0], 65536);

    // R14: transmit on channel B
    ctl_write(1'b1, 5, 8'h08); ctl_write(1'b1, 1, 8'h02);
    bus_op(1'b1, 1'b1, 1'b1, 8'h3C);
    check("R14 tx strobe B", tx_valid, 2'b10);
    check("R14 tx byte B", tx_data[15:8], 8'h3C);
    ctl_read(1'b0, 3, rv); check("R14 RR3 B tx pend", rv, 8'h02);
    ctl_read(1'b1, 3, rv); check("R14 RR3 on B", rv, 8'h00);
    ctl_read(1'b1, 0, rv); check("R14 RR0 B", rv, 8'h04);
    ctl_write(1'b1, 0, 8'h28);
    ctl_read(1'b0, 3, rv); check("R4 tx pend cleared", rv, 8'h00);

    // R10 / R5 / R13: loopback on channel A
    ctl_write(1'b0, 5, 8'h08); ctl_write(1'b0, 14, 8'h10); ctl_write(1'b0, 1, 8'h02);
    bus_op(1'b1, 1'b1, 1'b0, 8'h81);
    check("R10 no tx strobe in loopback", tx_valid, 2'b00);
    ctl_read(1'b0, 0, rv); check("R10 RR0 rx avail", rv, 8'h15);
    ctl_read(1'b0, 3, rv); check("R10 RR3 tx held", rv, 8'h20);
    ctl_write(1'b0, 0, 8'h38);
    ctl_read(1'b0, 3, rv); check("R5 tx released", rv, 8'h30);
    ctl_write(1'b0, 0, 8'h28);
    ctl_read(1'b0, 3, rv); check("R4 tx ack A", rv, 8'h20);
    bus_op(1'b0, 1'b1, 1'b0, 8'h00);
    check("R13 data read", bus_rdata, 8'h81);
    ctl_read(1'b0, 0, rv); check("R13 RR0 after read", rv, 8'h14);
    ctl_read(1'b0, 3, rv); check("R13 RR3 after read", rv, 8'h00);

    // R6: soft resets across channels
    ctl_write(1'b0, 9, 8'h40);
    ctl_read(1'b1, 0, rv);  check("R6 RR0 B", rv, 8'h44);
    ctl_read(1'b1, 1, rv);  check("R6 RR1 B", rv, 8'h07);
    ctl_read(1'b1, 15, rv); check("R6 RR15 B", rv, 8'hF8);
    ctl_read(1'b1, 12, rv); check("R6 RR12 B kept", rv, 8'h11);
    ctl_read(1'b0, 0, rv);  check("R6 RR0 A untouched", rv, 8'h14);
    ctl_write(1'b1, 9, 8'h80);
    ctl_read(1'b0, 0, rv);  check("R6 RR0 A", rv, 8'h54);
    ctl_read(1'b0, 15, rv); check("R6 RR15 A", rv, 8'hF8);
    idle(2);
    check("R6 A format after soft", {fmt_bits[3:0], stop2[0]}, {4'd5, 1'b0});

    // R7: hard reset
    ctl_write(1'b0, 9, 8'hC0);
    ctl_read(1'b0, 0, rv);  check("R7 RR0 A", rv, 8'h54);
    ctl_read(1'b1, 0, rv);  check("R7 RR0 B", rv, 8'h44);
    ctl_write(1'b0, 5, 8'h08);
    bus_op(1'b1, 1'b1, 1'b0, 8'h5E);
    check("R7 loopback forced on", tx_valid, 2'b00);
    bus_op(1'b0, 1'b1, 1'b0, 8'h00);
    check("R7 looped byte", bus_rdata, 8'h5E);

    // R11: device reset again
    @(negedge clk); rst = 1'b1;
    idle(2); rst = 1'b0;
    ctl_read(1'b0, 0, rv);  check("R11 RR0 A again", rv, 8'h04);
    ctl_read(1'b0, 12, rv); check("R11 RR12 A cleared", rv, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule